// File: doc/BRIEF.md
# Serially Loaded Control Point Override Array

This block lets a test controller force a set of internal control points to chosen values while feeding it only one data bit at a time. Each accepted bit is steered by a decoder into one holding flop of a bank of `NUM_PTS` flops. The target flop is named either by an internal wrapping counter or by a small address bus, depending on a build parameter. Loading a full vector therefore takes `NUM_PTS` accepted transfers.

Every control point has its own 2-to-1 selector. With the test mode pin low the selector forwards the functional line unchanged. With it high, the selector drives the held bit instead. Because the bits are held, a whole vector can be loaded first and then applied in one step. Leaving test mode and entering it again does not disturb the held bits.

The serial bit arrives on a valid/ready port. A transfer happens on a rising clock edge when `wr_valid` and `wr_ready` are both high. `wr_bit` and `wr_addr` must stay stable while `wr_valid` is high and `wr_ready` is low. In counter mode `wr_ready` is always high, so the block never applies back-pressure. In address mode `wr_ready` is low only while `wr_addr` names no existing point; a valid beat then stalls until the address changes.

Top module: `cpl_ctrl_array`

## Requirements
- R1: While `rst_n` is low, and after it is released, every holding flop is 0 and the internal counter is 0. With `test_mode` high and no transfer since reset, `ctrl_out` is all zeros.
- R2: While `test_mode` is 0, `ctrl_out` equals `func_in` bit for bit, with no clock delay.
- R3: While `test_mode` is 1, bit i of `ctrl_out` equals holding flop i, for every i.
- R4: On a transfer, the flop at the current address takes the value of `wr_bit`. The new value is visible on `ctrl_out` after that edge.
- R5: In counter mode the first transfer after reset writes point 0. Each transfer then advances the address by one. After point `NUM_PTS-1` the address returns to 0, so transfer k writes point k mod `NUM_PTS`.
- R6: A flop that is not addressed by a transfer keeps its value. A cycle with `wr_valid` low changes no flop and does not move the counter.
- R7: Changing `test_mode` leaves every held bit unchanged.
- R8: In address mode the transfer writes point `wr_addr` (binary). `wr_ready` is 0 exactly when `wr_addr >= NUM_PTS`; no flop changes while `wr_ready` is 0.
- R9: In counter mode `wr_ready` is always 1, and the value on `wr_addr` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode | input | 1 | 1 selects the held bits onto `ctrl_out` |
| wr_valid | input | 1 | Serial bit offered |
| wr_ready | output | 1 | Block accepts the offered bit |
| wr_bit | input | 1 | Serial test data bit |
| wr_addr | input | ADDR_W | Point index, used in address mode only |
| func_in | input | NUM_PTS | Functional values of the control points |
| ctrl_out | output | NUM_PTS | Values driven onto the control points |

## Verification
The hardest case to reach from the ports is the counter wrap. The counter is invisible, so a wrong wrap point shows up only when a later vector lands on the wrong point. The stimulus first loads complete vectors of distinct patterns across several wraps. It then interleaves idle cycles, test mode toggles and random `wr_addr` values, with a bench model that tracks the counter independently. For address mode, a second instance is driven with the two out-of-range codes so that stalled beats can be seen leaving the held bits alone.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
  typedef enum logic {
    ADDR_COUNTER = 1'b0,
    ADDR_DIRECT  = 1'b1
  } addr_src_e;

  function automatic int addr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cpl_addr_gen.sv
module cpl_addr_gen
  import cpl_pkg::*;
#(
  parameter int        NUM_PTS = 6,
  parameter int        AW      = 3,
  parameter addr_src_e SRC     = ADDR_COUNTER
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr,
  output logic          in_range
);
  localparam logic [AW-1:0] LAST = AW'(NUM_PTS - 1);
  localparam logic [AW:0]   NUM  = (AW + 1)'(NUM_PTS);

  generate
    if (SRC == ADDR_COUNTER) begin : g_cnt
      logic [AW-1:0] cnt_q;
      logic          unused_ext;
      assign unused_ext = ^ext_addr;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (fire)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign addr     = cnt_q;
      assign in_range = 1'b1;

      assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cnt_q == LAST) |=> (cnt_q == '0));
      assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
      assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cnt_q));
      assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q} < NUM));
    end else begin : g_dir
      assign addr     = ext_addr;
      assign in_range = ({1'b0, ext_addr} < NUM);

      assert_fire_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ({1'b0, addr} < NUM));
    end
  endgenerate
endmodule

// File: rtl/cpl_demux.sv
module cpl_demux #(
  parameter int NUM_PTS = 6,
  parameter int AW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [AW-1:0]      addr,
  output logic [NUM_PTS-1:0] we
);
  generate
    for (genvar i = 0; i < NUM_PTS; i++) begin : g_dec
      assign we[i] = fire && (addr == AW'(i));
    end
  endgenerate

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));
  assert_fire_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($countones(we) == 1));
endmodule

// File: rtl/cpl_latch_bank.sv
module cpl_latch_bank #(
  parameter int NUM_PTS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PTS-1:0] we,
  input  logic               din,
  output logic [NUM_PTS-1:0] q
);
  generate
    for (genvar i = 0; i < NUM_PTS; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q[i] <= 1'b0;
        else if (we[i]) q[i] <= din;
      end

      assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we[i] |=> (q[i] == $past(din)));
      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we[i] |=> $stable(q[i]));
    end
  endgenerate
endmodule

// File: rtl/cpl_point_mux.sv
module cpl_point_mux #(
  parameter int NUM_PTS = 6
) (
  input  logic               test_mode,
  input  logic [NUM_PTS-1:0] func_in,
  input  logic [NUM_PTS-1:0] held,
  output logic [NUM_PTS-1:0] ctrl_out
);
  generate
    for (genvar i = 0; i < NUM_PTS; i++) begin : g_sel
      assign ctrl_out[i] = test_mode ? held[i] : func_in[i];
    end
  endgenerate
endmodule

// File: rtl/cpl_ctrl_array.sv
module cpl_ctrl_array
  import cpl_pkg::*;
#(
  parameter int        NUM_PTS  = 6,
  parameter addr_src_e ADDR_SRC = ADDR_COUNTER,
  parameter int        ADDR_W   = addr_width(NUM_PTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               test_mode,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic               wr_bit,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_PTS-1:0] func_in,
  output logic [NUM_PTS-1:0] ctrl_out
);
  logic              fire;
  logic [ADDR_W-1:0] cur_addr;
  logic              in_range;
  logic [NUM_PTS-1:0] we;
  logic [NUM_PTS-1:0] held;

  assign wr_ready = in_range;
  assign fire     = wr_valid && wr_ready;

  cpl_addr_gen #(.NUM_PTS(NUM_PTS), .AW(ADDR_W), .SRC(ADDR_SRC)) u_addr (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ext_addr(wr_addr),
    .addr(cur_addr), .in_range(in_range)
  );

  cpl_demux #(.NUM_PTS(NUM_PTS), .AW(ADDR_W)) u_dmx (
    .clk(clk), .rst_n(rst_n), .fire(fire), .addr(cur_addr), .we(we)
  );

  cpl_latch_bank #(.NUM_PTS(NUM_PTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .din(wr_bit), .q(held)
  );

  cpl_point_mux #(.NUM_PTS(NUM_PTS)) u_mux (
    .test_mode(test_mode), .func_in(func_in), .held(held), .ctrl_out(ctrl_out)
  );

  assert_stall_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> $stable(held));
  assert_mode_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode != $past(test_mode) && !$past(fire)) |-> $stable(held));
  assert_test_view_R3: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> (ctrl_out == held));
  assert_func_view_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (ctrl_out == func_in));
endmodule

// File: tb/tb_cpl_ctrl_array.sv
`timescale 1ns/1ps
module tb_cpl_ctrl_array;
  import cpl_pkg::*;
  localparam int N  = 6;
  localparam int AW = 3;

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic          tm, vld, bitv;
  logic [AW-1:0] adr;
  logic [N-1:0]  fin;
  logic          rdy;
  logic [N-1:0]  cout;

  logic          d_tm, d_vld, d_bit;
  logic [AW-1:0] d_adr;
  logic [N-1:0]  d_fin;
  logic          d_rdy;
  logic [N-1:0]  d_out;

  cpl_ctrl_array #(.NUM_PTS(N), .ADDR_SRC(ADDR_COUNTER)) dut (
    .clk(clk), .rst_n(rst_n), .test_mode(tm), .wr_valid(vld), .wr_ready(rdy),
    .wr_bit(bitv), .wr_addr(adr), .func_in(fin), .ctrl_out(cout));

  cpl_ctrl_array #(.NUM_PTS(N), .ADDR_SRC(ADDR_DIRECT)) dut_dir (
    .clk(clk), .rst_n(rst_n), .test_mode(d_tm), .wr_valid(d_vld), .wr_ready(d_rdy),
    .wr_bit(d_bit), .wr_addr(d_adr), .func_in(d_fin), .ctrl_out(d_out));

  int checks = 0, errors = 0;
  logic [N-1:0] m_lat, d_lat;
  int m_cnt;
  bit done = 0;

  function automatic logic [N-1:0] exp_out(input logic t, input logic [N-1:0] f,
                                           input logic [N-1:0] l);
    return t ? l : f;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic v, input logic b,
                      input logic [AW-1:0] a, input logic [N-1:0] f, input string req);
    @(negedge clk);
    tm = t; vld = v; bitv = b; adr = a; fin = f;
    #1;
    chk("R9", N'(rdy), N'(1'b1));
    chk(req, cout, exp_out(t, f, m_lat));
    @(posedge clk);
    if (v) begin
      m_lat[m_cnt] = b;
      m_cnt = (m_cnt == N - 1) ? 0 : m_cnt + 1;
    end
    @(negedge clk); #1;
    chk(req, cout, exp_out(t, f, m_lat));
    vld = 0;
  endtask

  task automatic dstep(input logic v, input logic b, input logic [AW-1:0] a, input string req);
    @(negedge clk);
    d_tm = 1; d_vld = v; d_bit = b; d_adr = a; d_fin = '0;
    #1;
    chk("R8", N'(d_rdy), N'(a < N));
    @(posedge clk);
    if (v && a < N) d_lat[a] = b;
    @(negedge clk); #1;
    chk(req, d_out, d_lat);
    d_vld = 0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat;
    void'($urandom(1234));
    tm = 1; vld = 0; bitv = 0; adr = 0; fin = '1;
    d_tm = 1; d_vld = 0; d_bit = 0; d_adr = 0; d_fin = '0;
    m_lat = '0; d_lat = '0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", cout, '0);
    chk("R1", d_out, '0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1", cout, '0);

    // R5: load 101101 from point 0 upward, then wrap to point 0
    pat = 6'b101101;
    for (int i = 0; i < N; i++) step(1, 1, pat[i], 3'(i), '0, "R5");
    chk("R5", cout, pat);
    step(1, 1, 1'b0, 3'd7, '0, "R5");
    chk("R5", cout, 6'b101100);

    // R6: idle cycles change nothing
    for (int i = 0; i < 4; i++) step(1, 0, 1'b1, 3'(i), '0, "R6");
    chk("R6", cout, 6'b101100);

    // R7: leave and re-enter test mode
    step(0, 0, 0, 0, 6'b010101, "R2");
    step(1, 0, 0, 0, 6'b111111, "R7");
    chk("R7", cout, 6'b101100);

    // R4: single write to point 1 (counter at 1) changes only that point
    step(1, 1, 1'b0, 3'd5, '0, "R4");
    chk("R4", cout, 6'b101100 & ~6'b000010);

    // random mix (R2, R3, R4, R5, R9)
    for (int i = 0; i < 400; i++) begin
      logic t;
      t = 1'($urandom);
      step(t, 1'($urandom), 1'($urandom), 3'($urandom), N'($urandom),
           t ? "R3" : "R2");
    end

    // address mode: R8
    dstep(1, 1, 3'd3, "R8");
    dstep(1, 1, 3'd0, "R8");
    dstep(1, 1, 3'd6, "R8");
    dstep(1, 0, 3'd7, "R8");
    dstep(1, 0, 3'd3, "R8");
    dstep(1, 1, 3'd5, "R8");
    for (int i = 0; i < 100; i++)
      dstep(1'($urandom), 1'($urandom), 3'($urandom), "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule